// File: doc/BRIEF.md
# Late-Write Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM built so that reads and writes can follow each other on every clock cycle with no idle cycle between them. Address, command and byte enables are taken on the rising clock edge. The write data for a write is taken on a later edge: one edge after the address in flow-through mode and two edges after it in pipelined mode. Because of this delay, a read can follow a write at once.

The static `flow_mode` input selects the read path. In flow-through mode the read result is valid in the cycle after the edge that took the read. In pipelined mode it goes through an output register and is valid one cycle later. In pipelined mode a read can address a word whose write data has not yet arrived. The block then forwards the arriving data lane by lane, so the read returns the new data.

Bursts of four beats are started by a load command and continued with an advance input. The two low address bits step in either linear or interleaved order. An output-enable input and a sleep input both switch off the read-data drive at once, without waiting for a clock edge. Sleep also blocks new commands.

Top module: `late_write_sram`

## Requirements
- R1: A load command (`adv`=0) is accepted only when `chip_en_a`, `chip_en_b` and `chip_en_c` are all 1 and `sleep` is 0. Any other load cycle is a deselect: it starts no read or write and ends any burst.
- R2: In flow-through mode (`flow_mode`=1) the data of a read taken at edge t is driven (`rdata_drive`=1) in the cycle after edge t. In pipelined mode (`flow_mode`=0) it is driven in the cycle after edge t+1. Only one cycle is driven per read beat.
- R3: A write taken at edge t stores the `wdata` present at edge t+1 (flow-through) or at edge t+2 (pipelined). Reads and writes may alternate on consecutive edges with no idle cycle.
- R4: Data is split into 9-bit lanes, with lane i at bits [9i+8:9i]. A 1 in `byte_en[i]`, taken with the write address, writes lane i. Lanes whose enable is 0 keep their old value.
- R5: In pipelined mode, a read that addresses the word written by the write whose data arrives at the edge that loads the read output returns that new data in the enabled lanes and the array value in the other lanes.
- R6: With `interleave`=0, burst beat k (k=0..3) uses the load address with its two low bits replaced by (start + k) mod 4. The upper bits stay fixed.
- R7: With `interleave`=1, burst beat k uses the low bits start XOR k.
- R8: An advance cycle (`adv`=1) after an accepted load or advance continues the same operation and ignores `wr` and the chip enables. An advance after a deselect, a sleep cycle or reset does nothing.
- R9: `oe`=0 forces `rdata_drive` to 0 and `rdata` to zero at once, with no clock edge needed. `rdata` is zero whenever it is not driven.
- R10: While `sleep`=1, commands are ignored and `rdata_drive` is 0. The array keeps its contents. Writes accepted before sleep still take their late data. Commands are accepted again on the first edge after `sleep` returns to 0.
- R11: Reset (`rst_n`=0) cancels all pending reads, writes and bursts and leaves `rdata_drive` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| flow_mode | input | 1 | Static mode select: 1 for flow-through, 0 for pipelined |
| addr | input | ADDR_W | Word address for load commands |
| chip_en_a | input | 1 | Chip enable, active high |
| chip_en_b | input | 1 | Chip enable, active high |
| chip_en_c | input | 1 | Chip enable, active high |
| wr | input | 1 | 1 for write, 0 for read, on load commands |
| byte_en | input | LANES | Write enable per 9-bit lane |
| adv | input | 1 | 1 continues a burst, 0 loads a new command |
| interleave | input | 1 | Burst order: 0 for linear, 1 for interleaved |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous power-down request |
| wdata | input | LANES*LANE_W | Late write data |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_drive | output | 1 | 1 when `rdata` would be driven onto the bus |

## Verification
The bench builds the block with ADDR_W=6, LANES=4 and LANE_W=9, which gives 64 words of 36 bits. It writes every word in a single back-to-back sweep, so each later read has a known expected value. With this depth, bursts run inside 4-word groups, and both the wrap of the linear order and the XOR pattern of the interleaved order show in the addresses read. Four lanes are enough to check a single-lane write, both when the merged word goes to the array and when it is forwarded straight to a pipelined read.

// File: rtl/late_write_sram.sv
module late_write_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flow_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              chip_en_a,
  input  logic              chip_en_b,
  input  logic              chip_en_c,
  input  logic              wr,
  input  logic [LANES-1:0]  byte_en,
  input  logic              adv,
  input  logic              interleave,
  input  logic              oe,
  input  logic              sleep,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rdata_drive
);

  logic              sel, load, cont, go, go_wr;
  logic              b_active, b_wr;
  logic [ADDR_W-3:0] b_hi;
  logic [1:0]        b_base, b_cnt, nxt_cnt, low;
  logic [ADDR_W-1:0] cur_a, r_addr, w1_a, w2_a, cm_a;
  logic              r_valid, w1_v, w2_v, q_valid, cm_v;
  logic [LANES-1:0]  w1_be, w2_be, cm_be;
  logic [DW-1:0]     mem [DEPTH];
  logic [DW-1:0]     rd_raw, fwd, q_data;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [LANES-1:0] be);
    logic [DW-1:0] r;
    r = old_w;
    for (int i = 0; i < LANES; i++)
      if (be[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    return r;
  endfunction

  assign sel     = chip_en_a & chip_en_b & chip_en_c & ~sleep;
  assign load    = sel & ~adv;
  assign cont    = ~sleep & adv & b_active;
  assign go      = load | cont;
  assign go_wr   = load ? wr : b_wr;
  assign nxt_cnt = b_cnt + 2'd1;
  assign low     = interleave ? (b_base ^ nxt_cnt) : (b_base + nxt_cnt);
  assign cur_a   = load ? addr : {b_hi, low};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_active <= 1'b0;
      b_wr     <= 1'b0;
      b_hi     <= '0;
      b_base   <= '0;
      b_cnt    <= '0;
      r_valid  <= 1'b0;
      w1_v     <= 1'b0;
      w2_v     <= 1'b0;
      q_valid  <= 1'b0;
    end else begin
      if (load) begin
        b_active <= 1'b1;
        b_wr     <= wr;
        b_hi     <= addr[ADDR_W-1:2];
        b_base   <= addr[1:0];
        b_cnt    <= 2'd0;
      end else if (cont) begin
        b_cnt    <= nxt_cnt;
      end else begin
        b_active <= 1'b0;
      end
      r_valid <= go & ~go_wr;
      w1_v    <= go & go_wr;
      w2_v    <= w1_v;
      q_valid <= r_valid;
    end
  end

  always_ff @(posedge clk) begin
    r_addr <= cur_a;
    w1_a   <= cur_a;
    w1_be  <= byte_en;
    w2_a   <= w1_a;
    w2_be  <= w1_be;
    q_data <= fwd;
  end

  // commit stage: one edge late in flow-through, two in pipelined
  assign cm_v  = flow_mode ? w1_v  : w2_v;
  assign cm_a  = flow_mode ? w1_a  : w2_a;
  assign cm_be = flow_mode ? w1_be : w2_be;

  always_ff @(posedge clk)
    if (cm_v) mem[cm_a] <= merge(mem[cm_a], wdata, cm_be);

  assign rd_raw = mem[r_addr];
  assign fwd    = (w2_v && w2_a == r_addr) ? merge(rd_raw, wdata, w2_be) : rd_raw;

  assign rdata_drive = oe & ~sleep & (flow_mode ? r_valid : q_valid);
  assign rdata       = rdata_drive ? (flow_mode ? rd_raw : q_data) : '0;

  assert_deselect_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !adv && !(chip_en_a && chip_en_b && chip_en_c)) |=> (!r_valid && !w1_v));

  assert_pipe_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_mode && !sleep && !adv && chip_en_a && chip_en_b && chip_en_c && !wr)
      |=> ##1 q_valid);

  assert_one_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({r_valid, w1_v}));

  assert_no_orphan_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !b_active) |=> (!r_valid && !w1_v));

  assert_sleep_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!r_valid && !w1_v));

endmodule

// File: tb/late_write_sram_test.sv
`timescale 1ns/1ps
module late_write_sram_test;

  typedef struct packed {
    logic        adv, wr, sel, ilv;
    logic [3:0]  be;
    logic [5:0]  a;
    logic [35:0] wd;
    logic        dv;
    logic [35:0] ex;
  } vec_t;

  function automatic logic [35:0] pat(input logic [5:0] a);
    return {4{3'b101, a}};
  endfunction

  localparam logic [35:0] X1 = 36'h123456789;
  localparam logic [35:0] X2 = 36'hFEDCBA987;
  localparam logic [35:0] LM = 36'h00003FE00;
  localparam logic [35:0] M9 = (pat(6'd9) & ~LM) | (X2 & LM);
  localparam logic [35:0] W0 = 36'h100000001;
  localparam logic [35:0] W1 = 36'h200000002;
  localparam logic [35:0] W2 = 36'h300000003;
  localparam logic [35:0] W3 = 36'h400000004;
  localparam int NV = 41;

  // pipelined-mode vectors: row k is applied at edge k and checked after it
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b1,1'b0,4'hF,6'd5, 36'd0,1'b0,36'd0},
    '{1'b0,1'b0,1'b1,1'b0,4'hF,6'd6, 36'd0,1'b1,pat(6'd5)},
    '{1'b0,1'b1,1'b1,1'b0,4'hF,6'd7, 36'd0,1'b1,pat(6'd6)},
    '{1'b0,1'b0,1'b1,1'b0,4'hF,6'd7, 36'd0,1'b0,36'd0},
    '{1'b0,1'b0,1'b1,1'b0,4'hF,6'd8, X1,   1'b1,X1},
    '{1'b0,1'b1,1'b1,1'b0,4'h2,6'd9, 36'd0,1'b1,pat(6'd8)},
    '{1'b0,1'b0,1'b1,1'b0,4'hF,6'd9, 36'd0,1'b0,36'd0},
    '{1'b0,1'b0,1'b0,1'b0,4'hF,6'd0, X2,   1'b1,M9},
    '{1'b0,1'b0,1'b0,1'b0,4'hF,6'd0, 36'd0,1'b0,36'd0},
    '{1'b0,1'b0,1'b1,1'b0,4'hF,6'd9, 36'd0,1'b0,36'd0},
    '{1'b0,1'b0,1'b0,1'b0,4'hF,6'd0, 36'd0,1'b1,M9},
    '{1'b0,1'b0,1'b0,1'b0,4'hF,6'd5, 36'd0,1'b0,36'd0},
    '{1'b0,1'b1,1'b0,1'b0,4'hF,6'd5, 36'd0,1'b0,36'd0},
    '{1'b0,1'b0,1'b1,1'b0,4'hF,6'd6, 36'd0,1'b0,36'd0},
    '{1'b1,1'b0,1'b1,1'b0,4'hF,6'd0, 36'd0,1'b1,pat(6'd6)},
    '{1'b1,1'b0,1'b1,1'b0,4'hF,6'd0, 36'd0,1'b1,X1},
    '{1'b1,1'b0,1'b1,1'b0,4'hF,6'd0, 36'd0,1'b1,pat(6'd4)},
    '{1'b0,1'b0,1'b0,1'b0,4'hF,6'd0, 36'd0,1'b1,pat(6'd5)},
    '{1'b0,1'b0,1'b0,1'b0,4'hF,6'd0, 36'd0,1'b0,36'd0},
    '{1'b0,1'b0,1'b1,1'b1,4'hF,6'd5, 36'd0,1'b0,36'd0},
    '{1'b1,1'b0,1'b1,1'b1,4'hF,6'd0, 36'd0,1'b1,pat(6'd5)},
    '{1'b1,1'b0,1'b0,1'b1,4'hF,6'd0, 36'd0,1'b1,pat(6'd4)},
    '{1'b1,1'b1,1'b1,1'b1,4'hF,6'd0, 36'd0,1'b1,X1},
    '{1'b0,1'b0,1'b0,1'b1,4'hF,6'd0, 36'd0,1'b1,pat(6'd6)},
    '{1'b0,1'b0,1'b0,1'b0,4'hF,6'd0, 36'd0,1'b0,36'd0},
    '{1'b0,1'b1,1'b1,1'b0,4'hF,6'd10,36'd0,1'b0,36'd0},
    '{1'b1,1'b0,1'b1,1'b0,4'hF,6'd0, 36'd0,1'b0,36'd0},
    '{1'b1,1'b0,1'b1,1'b0,4'hF,6'd0, W0,   1'b0,36'd0},
    '{1'b1,1'b0,1'b1,1'b0,4'hF,6'd0, W1,   1'b0,36'd0},
    '{1'b0,1'b0,1'b0,1'b0,4'hF,6'd0, W2,   1'b0,36'd0},
    '{1'b0,1'b0,1'b0,1'b0,4'hF,6'd0, W3,   1'b0,36'd0},
    '{1'b0,1'b0,1'b1,1'b0,4'hF,6'd8, 36'd0,1'b0,36'd0},
    '{1'b0,1'b0,1'b1,1'b0,4'hF,6'd9, 36'd0,1'b1,W2},
    '{1'b0,1'b0,1'b1,1'b0,4'hF,6'd10,36'd0,1'b1,W3},
    '{1'b0,1'b0,1'b1,1'b0,4'hF,6'd11,36'd0,1'b1,W0},
    '{1'b0,1'b0,1'b0,1'b0,4'hF,6'd0, 36'd0,1'b1,W1},
    '{1'b0,1'b0,1'b0,1'b0,4'hF,6'd0, 36'd0,1'b0,36'd0},
    '{1'b1,1'b1,1'b1,1'b0,4'hF,6'd0, 36'd0,1'b0,36'd0},
    '{1'b0,1'b0,1'b0,1'b0,4'hF,6'd0, 36'd0,1'b0,36'd0},
    '{1'b0,1'b0,1'b1,1'b0,4'hF,6'd11,36'd0,1'b0,36'd0},
    '{1'b0,1'b0,1'b0,1'b0,4'hF,6'd0, 36'd0,1'b1,W1}
  };

  logic        clk = 1'b0, rst_n = 1'b0, flow_mode = 1'b1;
  logic [5:0]  addr = '0;
  logic        ce = 1'b0, wr = 1'b0, adv = 1'b0, interleave = 1'b0;
  logic        oe = 1'b1, sleep = 1'b0;
  logic [3:0]  byte_en = 4'hF;
  logic [35:0] wdata = '0, rdata;
  logic        rdata_drive;
  int          total = 0, bad = 0;

  always #2.5 clk = ~clk;

  late_write_sram #(.ADDR_W(6), .LANES(4), .LANE_W(9)) uut (
    .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .addr(addr),
    .chip_en_a(ce), .chip_en_b(ce), .chip_en_c(ce), .wr(wr), .byte_en(byte_en),
    .adv(adv), .interleave(interleave), .oe(oe), .sleep(sleep), .wdata(wdata),
    .rdata(rdata), .rdata_drive(rdata_drive));

  task automatic chk(input string tag, input logic ed, input logic [35:0] e);
    total++;
    if (rdata_drive !== ed || rdata !== e) begin
      bad++;
      $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
               tag, rdata_drive, rdata, ed, e);
    end
  endtask

  task automatic set(input logic a_adv, input logic a_wr, input logic a_sel,
                     input logic a_ilv, input logic [3:0] a_be,
                     input logic [5:0] a_a, input logic [35:0] a_wd);
    adv = a_adv; wr = a_wr; ce = a_sel; interleave = a_ilv;
    byte_en = a_be; addr = a_a; wdata = a_wd;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    set(0, 0, 0, 0, 4'hF, 6'd0, 36'd0);
    repeat (n) step();
  endtask

  function automatic string rtag(input int i);
    if (i < 5)       return "R2 R3 R5 pipelined row";
    else if (i < 11) return "R4 R5 lane row";
    else if (i < 13) return "R1 deselect row";
    else if (i < 19) return "R6 linear burst row";
    else if (i < 25) return "R7 R8 interleaved burst row";
    else if (i < 37) return "R3 R6 write burst row";
    else             return "R8 orphan advance row";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: drive=%0b data=%h expected drive=x data=x", rdata_drive, rdata);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset state", 1'b0, 36'd0);
    rst_n = 1'b1;
    step();

    // flow-through fill: back-to-back writes, data one edge behind
    for (int a = 0; a <= 64; a++) begin
      set(0, 1'b1, a < 64, 0, 4'hF, 6'(a), a > 0 ? pat(6'(a - 1)) : 36'd0);
      step();
    end
    idle(2);

    set(0, 0, 1, 0, 4'hF, 6'd3, 36'd0); step();
    chk("R2 flow read same cycle", 1'b1, pat(6'd3));
    set(0, 0, 1, 0, 4'hF, 6'd63, 36'd0); step();
    chk("R2 flow back-to-back read", 1'b1, pat(6'd63));
    set(0, 1, 1, 0, 4'hF, 6'd12, 36'd0); step();
    chk("R3 flow write cycle undriven", 1'b0, 36'd0);
    set(0, 0, 1, 0, 4'hF, 6'd12, 36'h0ABCDEF01); step();
    chk("R3 flow read after single late write", 1'b1, 36'h0ABCDEF01);
    oe = 1'b0; #1;
    chk("R9 oe low forces undriven", 1'b0, 36'd0);
    oe = 1'b1; #1;
    chk("R9 oe restored", 1'b1, 36'h0ABCDEF01);
    idle(2);

    flow_mode = 1'b0;
    idle(1);
    for (int i = 0; i < NV; i++) begin
      set(TBL[i].adv, TBL[i].wr, TBL[i].sel, TBL[i].ilv, TBL[i].be, TBL[i].a, TBL[i].wd);
      step();
      chk($sformatf("%s %0d", rtag(i), i), TBL[i].dv, TBL[i].ex);
    end
    idle(2);

    // sleep: commands ignored, array kept, output off
    sleep = 1'b1;
    set(0, 1, 1, 0, 4'hF, 6'd20, 36'd0); step();
    chk("R10 sleep write ignored", 1'b0, 36'd0);
    set(0, 0, 0, 0, 4'hF, 6'd0, 36'h777777777); step();
    set(0, 0, 1, 0, 4'hF, 6'd20, 36'd0); step();
    step();
    chk("R10 sleep read ignored", 1'b0, 36'd0);
    sleep = 1'b0;
    set(0, 0, 1, 0, 4'hF, 6'd20, 36'd0); step();
    idle(1);
    chk("R10 resume read sees kept data", 1'b1, pat(6'd20));
    set(0, 0, 1, 0, 4'hF, 6'd21, 36'd0); step();
    sleep = 1'b1;
    idle(1);
    chk("R10 sleep forces undriven", 1'b0, 36'd0);
    sleep = 1'b0; #1;
    chk("R10 output returns when sleep drops", 1'b1, pat(6'd21));
    idle(2);

    set(0, 0, 1, 0, 4'hF, 6'd5, 36'd0); step();
    rst_n = 1'b0;
    idle(1);
    chk("R11 reset cancels pending read", 1'b0, 36'd0);
    rst_n = 1'b1;
    idle(2);
    chk("R11 idle after reset", 1'b0, 36'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule